// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits the current in one H-bridge load by chopping at a peak. While the bridge decoder asks for drive, the source side of the bridge is switched on. A digital trip line comes from an external current-sense comparator. When the trip line fires outside the blanking window, the source gate is cut. The source then stays off for a fixed number of cycles while the load current decays slowly through the sink side. After that wait, the source is switched on again.

During that off-time, a synchronous-rectification enable turns on the sink-side FET. This happens only after a crossover gap, so that the source and sink of one leg never conduct together. Each chop also pulls an active-low overcurrent flag. The flag is held by a timer that restarts on every chop, so it stays low for the whole of a run of continuous chopping. The flag only reports; it never feeds back into the drive. The blanking, off-time, crossover and flag-hold durations are all parameters counted in clock cycles.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst` is high and on the first sampling after it, `src_en` = 0, `sr_en` = 0 and `ocp_n` = 1.
- R2: When `drive_req` is sampled high with the block idle, `src_en` is 1 from the next cycle. It stays 1 for as long as no trip is accepted.
- R3: During the first `BLANK_CYC` cycles of every on-phase (cycle 0 is the first cycle with `src_en` = 1), `trip` is ignored. With `trip` held high from the start, `src_en` stays high for exactly `BLANK_CYC`+1 cycles.
- R4: A `trip` sampled high in an unblanked on-phase cycle, with `drive_req` high, makes `src_en` 0 from the next cycle.
- R5: After a chop, `src_en` stays low for exactly `OFF_CYC` cycles and then returns high, provided `drive_req` stays high. `trip` has no effect during the off-time.
- R6: `sr_en` is 1 only inside an off-time, from its cycle `XOVER_CYC` (0-based) up to its last cycle. `sr_en` and `src_en` are never 1 together, and `sr_en` never rises in the cycle right after `src_en` was 1.
- R7: `ocp_n` goes to 0 in the cycle after a chop. It returns to 1 only once `HOLD_CYC` cycles have passed with no further chop, because every chop restarts the hold count.
- R8: `ocp_n` has no effect on `src_en` or `sr_en`. A drop of `drive_req` does not cut the flag hold short.
- R9: `drive_req` sampled low forces `src_en` = 0 and `sr_en` = 0 from the next cycle, and abandons any off-time in progress. The next request starts a new on-phase with a full blanking window.
- R10: If `trip` never asserts, `src_en` stays high for the whole request and `ocp_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drive_req | input | 1 | Drive request from the bridge decoder |
| trip | input | 1 | Peak-current trip from the sense comparator |
| src_en | output | 1 | Source-side gate enable |
| sr_en | output | 1 | Sink-side synchronous-rectification enable for the off-time |
| ocp_n | output | 1 | Overcurrent flag, active low |

## Verification
The bench holds `trip` high from the first on-cycle to measure the blanking edge. A design that blanks one cycle too short or too long chops early or late, and the on-width differs from `BLANK_CYC`+1. Off-time width and the crossover gap are measured directly; an off-by-one in either shows up as a miscounted `src_en` low window or as an early `sr_en`.

The bench drops the request in the middle of an off-time and then re-requests with `trip` held high. This catches a design that resumes the stale off-time or skips the new blanking window. It also measures the flag hold after a single chop, and uses random chopping bursts to expose a hold timer that is not restarted on each chop.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } phase_e;

    typedef struct packed {
        logic src;
        logic sr;
    } drive_t;

    function automatic int unsigned span_bits(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/chop_phase.sv
module chop_phase
    import chop_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 750,
    parameter int unsigned OFF_CYC   = 7500,
    parameter int unsigned XOVER_CYC = 106
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   drive_req,
    input  logic   trip,
    output drive_t drv,
    output logic   chop
);
    localparam int unsigned W = span_bits(BLANK_CYC, OFF_CYC);
    localparam logic [W-1:0] BLANK_L = W'(BLANK_CYC);
    localparam logic [W-1:0] OFF_L   = W'(OFF_CYC - 1);
    localparam logic [W-1:0] XOVER_L = W'(XOVER_CYC);

    phase_e       ph;
    logic [W-1:0] cnt;
    logic         blank_done;

    assign blank_done = (cnt >= BLANK_L);
    assign chop       = (ph == PH_ON) && blank_done && trip && drive_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else if (!drive_req) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    ph  <= PH_ON;
                    cnt <= '0;
                end
                PH_ON: begin
                    if (chop) begin
                        ph  <= PH_OFF;
                        cnt <= '0;
                    end else if (!blank_done) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_OFF: begin
                    if (cnt == OFF_L) begin
                        ph  <= PH_ON;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    always_comb begin
        drv.src = (ph == PH_ON);
        drv.sr  = (ph == PH_OFF) && (cnt >= XOVER_L);
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !(drv.src && drv.sr)); // R6
    AST_SR_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.sr) |-> $past(!drv.src)); // R6
    AST_REQ_DROP_IDLES: assert property (@(posedge clk) disable iff (rst)
        !drive_req |=> (!drv.src && !drv.sr)); // R9
    AST_CHOP_CUTS_SRC: assert property (@(posedge clk) disable iff (rst)
        chop |=> (!drv.src && ph == PH_OFF)); // R4
    AST_BLANK_HOLDS_SRC: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ON && !blank_done && drive_req) |=> drv.src); // R3
    AST_IDLE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && drive_req) |=> drv.src); // R2

endmodule

// File: rtl/chop_fault_hold.sv
module chop_fault_hold #(
    parameter int unsigned HOLD_CYC = 75000
) (
    input  logic clk,
    input  logic rst,
    input  logic chop,
    output logic flag_n
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LAST_L = HW'(HOLD_CYC - 1);

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_n   <= 1'b1;
            hold_cnt <= '0;
        end else if (chop) begin
            flag_n   <= 1'b0;
            hold_cnt <= '0;
        end else if (!flag_n) begin
            if (hold_cnt == LAST_L) begin
                flag_n   <= 1'b1;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    AST_FLAG_ON_CHOP: assert property (@(posedge clk) disable iff (rst)
        chop |=> !flag_n); // R7
    AST_NO_RELEASE_ON_CHOP: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_n) |-> $past(!chop)); // R7

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 750,
    parameter int unsigned OFF_CYC   = 7500,
    parameter int unsigned XOVER_CYC = 106,
    parameter int unsigned HOLD_CYC  = 75000
) (
    input  logic clk,
    input  logic rst,
    input  logic drive_req,
    input  logic trip,
    output logic src_en,
    output logic sr_en,
    output logic ocp_n
);
    drive_t drv;
    logic   chop;

    chop_phase #(
        .BLANK_CYC (BLANK_CYC),
        .OFF_CYC   (OFF_CYC),
        .XOVER_CYC (XOVER_CYC)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .drive_req (drive_req),
        .trip      (trip),
        .drv       (drv),
        .chop      (chop)
    );

    chop_fault_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_fault (
        .clk    (clk),
        .rst    (rst),
        .chop   (chop),
        .flag_n (ocp_n)
    );

    assign src_en = drv.src;
    assign sr_en  = drv.sr;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!src_en && !sr_en && ocp_n)); // R1

endmodule

// File: tb/chop_ctrl_tb.sv
`timescale 1ns/1ps
module chop_ctrl_tb;
    localparam int unsigned BLANK = 6;
    localparam int unsigned OFFC  = 20;
    localparam int unsigned XOV   = 3;
    localparam int unsigned HOLD  = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drive_req = 1'b0;
    logic trip = 1'b0;
    logic src_en, sr_en, ocp_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state, built from the requirements
    int m_ph = 0;      // 0 idle, 1 on, 2 off
    int m_cnt = 0;
    int m_fc = 0;
    bit m_flag = 0;    // 1 = flag asserted

    always #2 clk = ~clk;

    chop_ctrl #(
        .BLANK_CYC (BLANK),
        .OFF_CYC   (OFFC),
        .XOVER_CYC (XOV),
        .HOLD_CYC  (HOLD)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .drive_req (drive_req),
        .trip      (trip),
        .src_en    (src_en),
        .sr_en     (sr_en),
        .ocp_n     (ocp_n)
    );

    function automatic bit exp_src();
        return m_ph == 1;
    endfunction
    function automatic bit exp_sr();
        return (m_ph == 2) && (m_cnt >= XOV);
    endfunction
    function automatic bit exp_flag_n();
        return !m_flag;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic model_step(input bit req, input bit trp);
        bit c;
        c = (m_ph == 1) && (m_cnt >= BLANK) && trp && req;
        if (!req) begin
            m_ph = 0; m_cnt = 0;
        end else if (m_ph == 0) begin
            m_ph = 1; m_cnt = 0;
        end else if (m_ph == 1) begin
            if (c) begin m_ph = 2; m_cnt = 0; end
            else if (m_cnt < BLANK) m_cnt++;
        end else begin
            if (m_cnt == OFFC - 1) begin m_ph = 1; m_cnt = 0; end
            else m_cnt++;
        end
        if (c) begin
            m_flag = 1; m_fc = 0;
        end else if (m_flag) begin
            if (m_fc == HOLD - 1) begin m_flag = 0; m_fc = 0; end
            else m_fc++;
        end
    endtask

    task automatic compare_all(input string tag);
        check(src_en === exp_src(), {tag, " src_en"}, int'(src_en), int'(exp_src()));
        check(sr_en === exp_sr(), {tag, " sr_en"}, int'(sr_en), int'(exp_sr()));
        check(ocp_n === exp_flag_n(), {tag, " ocp_n"}, int'(ocp_n), int'(exp_flag_n()));
    endtask

    task automatic tick(input bit req, input bit trp, input string tag);
        drive_req = req;
        trip = trp;
        @(posedge clk);
        model_step(req, trp);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int k;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(src_en === 1'b0, "R1 src_en in reset", int'(src_en), 0);
        check(sr_en === 1'b0, "R1 sr_en in reset", int'(sr_en), 0);
        check(ocp_n === 1'b1, "R1 ocp_n in reset", int'(ocp_n), 1);
        rst = 1'b0;
        tick(0, 0, "R1");

        // R10 / R2: no trip ever, source stays on, flag released
        for (int i = 0; i < 100; i++) tick(1, 0, "R10 R2");
        check(src_en === 1'b1 && ocp_n === 1'b1, "R10 steady on", int'({src_en, ocp_n}), 3);

        // R3: trip held from the start of an on-phase
        tick(0, 0, "R9"); tick(0, 0, "R9");
        n = 0;
        tick(1, 1, "R3");
        while (src_en === 1'b1 && n < 100) begin n++; tick(1, 1, "R3"); end
        check(n == BLANK + 1, "R3 blanked on-width", n, BLANK + 1);
        check(ocp_n === 1'b0, "R7 flag after chop", int'(ocp_n), 0);
        // R5 / R6: off-time width and crossover gap, trip still held
        n = 0; k = 0;
        while (src_en === 1'b0 && n < 100) begin
            n++;
            if (sr_en === 1'b1) k++;
            tick(1, 1, "R5 R6");
        end
        check(n == OFFC, "R5 off-time width", n, OFFC);
        check(k == OFFC - XOV, "R6 sr_en width", k, OFFC - XOV);

        // R9: drop request mid off-time, then re-request with trip held
        n = 0;
        while (src_en === 1'b1 && n < 100) begin n++; tick(1, 1, "R3"); end
        for (int i = 0; i < 4; i++) tick(1, 1, "R5");
        tick(0, 1, "R9");
        check(src_en === 1'b0 && sr_en === 1'b0, "R9 drop clears drive", int'({src_en, sr_en}), 0);
        check(ocp_n === 1'b0, "R8 flag survives drop", int'(ocp_n), 0);
        n = 0;
        tick(1, 1, "R9");
        while (src_en === 1'b1 && n < 100) begin n++; tick(1, 1, "R9"); end
        check(n == BLANK + 1, "R9 fresh blanking", n, BLANK + 1);

        // R7: single chop, measure hold length
        for (int i = 0; i < 3 * HOLD; i++) tick(0, 0, "R8");
        check(ocp_n === 1'b1, "R7 flag released", int'(ocp_n), 1);
        for (int i = 0; i < BLANK + 2; i++) tick(1, 0, "R2");
        tick(1, 1, "R4");
        check(src_en === 1'b0, "R4 chop cuts source", int'(src_en), 0);
        n = 0;
        while (ocp_n === 1'b0 && n < 1000) begin n++; tick(1, 0, "R7 R8"); end
        check(n == HOLD, "R7 flag hold length", n, HOLD);
        check(src_en === 1'b1, "R8 drive unaffected by flag", int'(src_en), 1);

        // random mix against the reference
        for (int i = 0; i < 5000; i++) begin
            bit rq;
            bit tp;
            rq = ($urandom % 100) < 93;
            tp = ($urandom % 100) < ((i / 500) % 2 == 0 ? 25 : 3);
            tick(rq, tp, "R2 R3 R4 R5 R6 R7 R9");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule